// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block decides, for one instruction at a time, which of ten hardware debug triggers fire. The ten triggers form five fixed pairs, and every trigger is bound by its position to one kind of access: an instruction fetch, a load or a store. Software-side logic programs each trigger through a single write port. One trigger is written per cycle, selected by an index. Each entry holds an enable, a match type, a select bit, a timing bit, an action bit, a chain bit and a 64-bit compare value.

For each instruction the pipeline presents an access-kind tag and one 64-bit value per trigger. The block computes a raw hit for every trigger. It then applies the pair rules: an unchained pair passes its raw hits through, while a chained pair fires as a unit only when both members hit and agree on timing. The result is a per-trigger fire vector, an any-fire flag, and the timing and action of the lowest-numbered firing trigger. A timing of 0 means the trap is taken before the instruction, and 1 means it is taken after. Results are combinational from the registered configuration and the current instruction inputs.

Top module: `trig_chain_resolver`

## Requirements
- R1: After reset (rst_ni low, asynchronous) every configuration field is zero, so no trigger fires for any instruction until one is written.
- R2: A write with cfg_valid_i high stores all fields into the trigger named by cfg_idx_i at the next rising clock edge. An index of 10 to 15 changes no trigger.
- R3: A trigger hits only when its enable is 1 and its compare succeeds. Match type 0 hits when the input value equals the stored value, 1 when the stored value is greater than or equal to the input, and 2 when the stored value is less than the input. Match type 3 never hits. All compares are unsigned.
- R4: The access kind is encoded as 0 for none, 1 for fetch, 2 for load and 3 for store. Triggers 0, 1, 6 and 8 watch fetches, triggers 2, 3 and 7 watch stores, and triggers 4, 5 and 9 watch loads. A trigger hits only for its own kind, and kind 0 hits nothing.
- R5: A load-kind trigger with its select bit set (a compare against load data) never hits. Select has no effect on other triggers.
- R6: In an unchained pair, each member fires exactly when it hits.
- R7: Pair p (triggers 2p and 2p+1) is chained when the chain bit of either member is 1. A chained pair fires both members when both hit, and neither member otherwise.
- R8: A chained pair whose members have different timing bits never fires.
- R9: The pair made of triggers 2 and 3 (both store) is always treated as unchained, whatever its chain bits hold.
- R10: any_fire_o is 1 when any fire bit is 1. timing_o and action_o are the timing and action bits of the lowest-indexed firing trigger, and both are 0 when nothing fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Index of the trigger to write |
| cfg_en_i | input | 1 | Enable field |
| cfg_mtype_i | input | 2 | Match type field |
| cfg_select_i | input | 1 | Select field (1 = data compare) |
| cfg_timing_i | input | 1 | Timing field (0 before, 1 after) |
| cfg_action_i | input | 1 | Action field |
| cfg_chain_i | input | 1 | Chain field |
| cfg_tdata_i | input | 64 | Compare value field |
| kind_i | input | 2 | Access kind of the current instruction |
| cmp_val_i | input | 640 | Per-trigger input value, trigger t at bits 64t+63:64t |
| fire_o | output | 10 | Per-trigger fire vector |
| any_fire_o | output | 1 | Any trigger fires |
| timing_o | output | 1 | Timing of the lowest firing trigger |
| action_o | output | 1 | Action of the lowest firing trigger |

## Verification
The sweeps target mixed-kind pairs. For example, with fetch and store in one pair, both members can never hit on the same access, so a chained mixed pair must stay silent. A resolver that ORs hits instead of ANDing them would fire there. The store pair is swept with its chain bit set, and a design that honours that bit would drop single-member hits on triggers 2 and 3. The sweeps also use compare values near the top of the 64-bit range, where a signed compare gives the wrong order. Other cases include select on load triggers, writes to indexes 10 to 15 (which would wrap onto real triggers if the index were truncated), and priority between several firing triggers. Wrong priority shows up as the timing or action of a higher-numbered trigger.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_LOAD  = 2'd2,
    KIND_STORE = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    MT_EQ    = 2'd0,
    MT_GE    = 2'd1,
    MT_LT    = 2'd2,
    MT_NEVER = 2'd3
  } mtype_e;

  typedef struct packed {
    logic   en;
    mtype_e mtype;
    logic   sel;
    logic   timing;
    logic   action;
    logic   chain;
  } trig_cfg_t;

  // fixed access kind per trigger position
  function automatic kind_e trig_kind(int unsigned idx);
    case (idx)
      0, 1, 6, 8: trig_kind = KIND_FETCH;
      2, 3, 7:    trig_kind = KIND_STORE;
      4, 5, 9:    trig_kind = KIND_LOAD;
      default:    trig_kind = KIND_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
`timescale 1ns/1ps
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int NUM_TRIG = 10,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_TRIG)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  trig_cfg_t                        cfg_i,
  input  logic [DATA_W-1:0]                tdata_i,
  output trig_cfg_t [NUM_TRIG-1:0]         cfg_o,
  output logic [NUM_TRIG-1:0][DATA_W-1:0]  tdata_o
);

  trig_cfg_t [NUM_TRIG-1:0]        cfg_q;
  logic [NUM_TRIG-1:0][DATA_W-1:0] tdata_q;

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_entry
    logic sel_w;
    assign sel_w = we_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g]   <= '0;
        tdata_q[g] <= '0;
      end else if (sel_w) begin
        cfg_q[g]   <= cfg_i;
        tdata_q[g] <= tdata_i;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign tdata_o = tdata_q;

endmodule

// File: rtl/trig_match.sv
`timescale 1ns/1ps
module trig_match
  import trig_pkg::*;
#(
  parameter int    DATA_W = 64,
  parameter kind_e KIND   = KIND_FETCH
) (
  input  trig_cfg_t          cfg_i,
  input  logic [DATA_W-1:0]  tdata_i,
  input  logic [DATA_W-1:0]  val_i,
  input  kind_e              kind_i,
  output logic               hit_o
);

  localparam bit IS_LOAD = (KIND == KIND_LOAD);

  logic cmp_ok;
  logic sel_block;

  always_comb begin
    unique case (cfg_i.mtype)
      MT_EQ:   cmp_ok = (tdata_i == val_i);
      MT_GE:   cmp_ok = (tdata_i >= val_i);
      MT_LT:   cmp_ok = (tdata_i <  val_i);
      default: cmp_ok = 1'b0;
    endcase
  end

  // load data compare unsupported
  assign sel_block = IS_LOAD && cfg_i.sel;
  assign hit_o     = cfg_i.en && (kind_i == KIND) && !sel_block && cmp_ok;

endmodule

// File: rtl/trig_pair.sv
`timescale 1ns/1ps
module trig_pair
  import trig_pkg::*;
#(
  parameter kind_e LO_KIND = KIND_FETCH,
  parameter kind_e HI_KIND = KIND_FETCH
) (
  input  logic [1:0] hit_i,
  input  logic [1:0] chain_i,
  input  logic [1:0] timing_i,
  output logic [1:0] fire_o,
  output logic       chain_eff_o
);

  localparam bit CHAIN_OK = !((LO_KIND == KIND_STORE) && (HI_KIND == KIND_STORE));

  logic both;

  assign chain_eff_o = CHAIN_OK && (|chain_i);
  assign both        = (&hit_i) && (timing_i[0] == timing_i[1]);
  assign fire_o      = chain_eff_o ? {both, both} : hit_i;

endmodule

// File: rtl/trig_chain_resolver.sv
`timescale 1ns/1ps
module trig_chain_resolver
  import trig_pkg::*;
#(
  parameter int  NUM_PAIRS = 5,
  parameter int  DATA_W    = 64,
  localparam int NUM_TRIG  = 2 * NUM_PAIRS,
  localparam int IDX_W     = $clog2(NUM_TRIG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_valid_i,
  input  logic [IDX_W-1:0]             cfg_idx_i,
  input  logic                         cfg_en_i,
  input  logic [1:0]                   cfg_mtype_i,
  input  logic                         cfg_select_i,
  input  logic                         cfg_timing_i,
  input  logic                         cfg_action_i,
  input  logic                         cfg_chain_i,
  input  logic [DATA_W-1:0]            cfg_tdata_i,
  input  logic [1:0]                   kind_i,
  input  logic [NUM_TRIG*DATA_W-1:0]   cmp_val_i,
  output logic [NUM_TRIG-1:0]          fire_o,
  output logic                         any_fire_o,
  output logic                         timing_o,
  output logic                         action_o
);

  trig_cfg_t                       wr_cfg;
  trig_cfg_t [NUM_TRIG-1:0]        cfg_q;
  logic [NUM_TRIG-1:0][DATA_W-1:0] tdata_q;
  logic [NUM_TRIG-1:0]             raw_hit;
  logic [NUM_TRIG-1:0]             timing_q;
  logic [NUM_TRIG-1:0]             action_q;
  logic [NUM_TRIG-1:0]             chain_q;
  logic [NUM_PAIRS-1:0]            chain_eff;
  kind_e                           kind;

  assign wr_cfg = '{en:     cfg_en_i,
                    mtype:  mtype_e'(cfg_mtype_i),
                    sel:    cfg_select_i,
                    timing: cfg_timing_i,
                    action: cfg_action_i,
                    chain:  cfg_chain_i};

  assign kind = kind_e'(kind_i);

  trig_cfg_regs #(
    .NUM_TRIG (NUM_TRIG),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_valid_i),
    .idx_i   (cfg_idx_i),
    .cfg_i   (wr_cfg),
    .tdata_i (cfg_tdata_i),
    .cfg_o   (cfg_q),
    .tdata_o (tdata_q)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    trig_match #(
      .DATA_W (DATA_W),
      .KIND   (trig_kind(g))
    ) u_match (
      .cfg_i   (cfg_q[g]),
      .tdata_i (tdata_q[g]),
      .val_i   (cmp_val_i[g*DATA_W +: DATA_W]),
      .kind_i  (kind),
      .hit_o   (raw_hit[g])
    );
    assign timing_q[g] = cfg_q[g].timing;
    assign action_q[g] = cfg_q[g].action;
    assign chain_q[g]  = cfg_q[g].chain;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    trig_pair #(
      .LO_KIND (trig_kind(2*p)),
      .HI_KIND (trig_kind(2*p+1))
    ) u_pair (
      .hit_i       (raw_hit[2*p+1 -: 2]),
      .chain_i     (chain_q[2*p+1 -: 2]),
      .timing_i    (timing_q[2*p+1 -: 2]),
      .fire_o      (fire_o[2*p+1 -: 2]),
      .chain_eff_o (chain_eff[p])
    );
  end

  assign any_fire_o = |fire_o;

  // lowest index wins
  always_comb begin
    timing_o = 1'b0;
    action_o = 1'b0;
    for (int t = NUM_TRIG - 1; t >= 0; t--) begin
      if (fire_o[t]) begin
        timing_o = timing_q[t];
        action_o = action_q[t];
      end
    end
  end

endmodule

// File: rtl/trig_chain_resolver_chk.sv
`timescale 1ns/1ps
module trig_chain_resolver_chk #(
  parameter int  NUM_PAIRS = 5,
  localparam int NUM_TRIG  = 2 * NUM_PAIRS
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_valid_i,
  input logic [1:0]           kind_i,
  input logic [NUM_TRIG-1:0]  raw_hit_i,
  input logic [NUM_PAIRS-1:0] chain_eff_i,
  input logic [NUM_TRIG-1:0]  timing_q_i,
  input logic [NUM_TRIG-1:0]  fire_o,
  input logic                 any_fire_o,
  input logic                 timing_o,
  input logic                 action_o
);

  logic cfg_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cfg_seen_q <= 1'b0;
    else if (cfg_valid_i) cfg_seen_q <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_seen_q |-> (fire_o == '0));

  p_no_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'd0) |-> (fire_o == '0));

  p_fire_needs_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o & ~raw_hit_i) == '0);

  p_idle_outputs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_fire_o |-> (!timing_o && !action_o));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
    p_chain_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_eff_i[p] |-> (fire_o[2*p] == fire_o[2*p+1]));

    p_chain_timing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chain_eff_i[p] && fire_o[2*p]) |-> (timing_q_i[2*p] == timing_q_i[2*p+1]));
  end

  if (NUM_PAIRS > 1) begin : g_store_chk
    p_store_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_hit_i[2] && !raw_hit_i[3]) |-> fire_o[2]);
  end

endmodule

bind trig_chain_resolver trig_chain_resolver_chk #(
  .NUM_PAIRS (NUM_PAIRS)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_i),
  .kind_i      (kind_i),
  .raw_hit_i   (raw_hit),
  .chain_eff_i (chain_eff),
  .timing_q_i  (timing_q),
  .fire_o      (fire_o),
  .any_fire_o  (any_fire_o),
  .timing_o    (timing_o),
  .action_o    (action_o)
);

// File: tb/trig_chain_resolver_tb_top.sv
`timescale 1ns/1ps
module trig_chain_resolver_tb_top;

  localparam int NT = 10;
  localparam int DW = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_valid_i = 1'b0;
  logic [3:0]        cfg_idx_i = '0;
  logic              cfg_en_i = 1'b0;
  logic [1:0]        cfg_mtype_i = '0;
  logic              cfg_select_i = 1'b0;
  logic              cfg_timing_i = 1'b0;
  logic              cfg_action_i = 1'b0;
  logic              cfg_chain_i = 1'b0;
  logic [DW-1:0]     cfg_tdata_i = '0;
  logic [1:0]        kind_i = '0;
  logic [NT*DW-1:0]  cmp_val_i = '0;
  logic [NT-1:0]     fire_o;
  logic              any_fire_o;
  logic              timing_o;
  logic              action_o;

  trig_chain_resolver dut_i (
    .clk_i, .rst_ni, .cfg_valid_i, .cfg_idx_i, .cfg_en_i, .cfg_mtype_i,
    .cfg_select_i, .cfg_timing_i, .cfg_action_i, .cfg_chain_i, .cfg_tdata_i,
    .kind_i, .cmp_val_i, .fire_o, .any_fire_o, .timing_o, .action_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  bit          m_en  [NT];
  int          m_mt  [NT];
  bit          m_sel [NT];
  bit          m_tim [NT];
  bit          m_act [NT];
  bit          m_ch  [NT];
  logic [63:0] m_td  [NT];
  logic [63:0] cur_v [NT];

  function automatic int kind_of(int t);
    if (t == 0 || t == 1 || t == 6 || t == 8) return 1;
    if (t == 2 || t == 3 || t == 7) return 3;
    return 2;
  endfunction

  function automatic bit exp_raw(int t, int k);
    bit c;
    if (!m_en[t] || k != kind_of(t)) return 0;
    if (k == 2 && m_sel[t]) return 0;
    case (m_mt[t])
      0: c = (m_td[t] == cur_v[t]);
      1: c = (m_td[t] >= cur_v[t]);
      2: c = (m_td[t] <  cur_v[t]);
      default: c = 0;
    endcase
    return c;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < NT; t++) begin
      m_en[t] = 0; m_mt[t] = 0; m_sel[t] = 0; m_tim[t] = 0;
      m_act[t] = 0; m_ch[t] = 0; m_td[t] = '0;
    end
  endtask

  task automatic wcfg(int idx, bit en, int mt, bit sel, bit tim, bit act, bit ch,
                      logic [63:0] td);
    @(negedge clk_i);
    cfg_valid_i  = 1'b1;
    cfg_idx_i    = 4'(idx);
    cfg_en_i     = en;
    cfg_mtype_i  = 2'(mt);
    cfg_select_i = sel;
    cfg_timing_i = tim;
    cfg_action_i = act;
    cfg_chain_i  = ch;
    cfg_tdata_i  = td;
    @(negedge clk_i);
    cfg_valid_i  = 1'b0;
    if (idx < NT) begin
      m_en[idx] = en; m_mt[idx] = mt; m_sel[idx] = sel; m_tim[idx] = tim;
      m_act[idx] = act; m_ch[idx] = ch; m_td[idx] = td;
    end
  endtask

  task automatic probe(int k, string tag);
    logic [NT-1:0] raw, ef;
    bit e_any, e_tim, e_act;
    @(negedge clk_i);
    kind_i = 2'(k);
    for (int t = 0; t < NT; t++) cmp_val_i[t*DW +: DW] = cur_v[t];
    #1;
    for (int t = 0; t < NT; t++) raw[t] = exp_raw(t, k);
    for (int p = 0; p < NT/2; p++) begin
      bit ch;
      ch = (m_ch[2*p] || m_ch[2*p+1]) &&
           !(kind_of(2*p) == 3 && kind_of(2*p+1) == 3);
      if (ch) begin
        ef[2*p]   = raw[2*p] && raw[2*p+1] && (m_tim[2*p] == m_tim[2*p+1]);
        ef[2*p+1] = ef[2*p];
      end else begin
        ef[2*p]   = raw[2*p];
        ef[2*p+1] = raw[2*p+1];
      end
    end
    e_any = |ef;
    e_tim = 0; e_act = 0;
    for (int t = NT - 1; t >= 0; t--)
      if (ef[t]) begin e_tim = m_tim[t]; e_act = m_act[t]; end
    checks++;
    if (fire_o !== ef || any_fire_o !== e_any || timing_o !== e_tim || action_o !== e_act) begin
      fails++;
      $display("FAIL %s kind=%0d: fire=%b any=%b tim=%b act=%b expected fire=%b any=%b tim=%b act=%b",
               tag, k, fire_o, any_fire_o, timing_o, action_o, ef, e_any, e_tim, e_act);
    end
  endtask

  task automatic all_kinds(string tag);
    for (int k = 0; k < 4; k++) probe(k, tag);
  endtask

  initial begin
    model_clear();
    for (int t = 0; t < NT; t++) cur_v[t] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: nothing fires out of reset
    all_kinds("R1 reset");
    for (int t = 0; t < NT; t++) cur_v[t] = 64'hFFFF_FFFF_FFFF_FFFF;
    all_kinds("R1 reset");

    // R3 R4 R5: single-trigger sweep of enable, match type, select, kind and value order
    for (int t = 0; t < NT; t++) begin
      for (int mt = 0; mt < 4; mt++)
        for (int sel = 0; sel < 2; sel++)
          for (int en = 0; en < 2; en++) begin
            logic [63:0] td;
            td = 64'h1000 + 64'(t);
            wcfg(t, en[0], mt, sel[0], t[0], ~t[0], 1'b0, td);
            for (int rel = 0; rel < 3; rel++) begin
              for (int u = 0; u < NT; u++) cur_v[u] = td + 64'(rel) - 64'd1;
              all_kinds("R3 R4 R5 sweep");
            end
          end
      wcfg(t, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    end

    // R3: unsigned ordering near the top of the range
    for (int mt = 1; mt < 3; mt++) begin
      wcfg(0, 1'b1, mt, 1'b0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0000);
      cur_v[0] = 64'h7FFF_FFFF_FFFF_FFFF; probe(1, "R3 unsigned");
      cur_v[0] = 64'hFFFF_FFFF_FFFF_FFFF; probe(1, "R3 unsigned");
      cur_v[0] = 64'h8000_0000_0000_0000; probe(1, "R3 unsigned");
    end
    wcfg(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);

    // R6 R7 R8 R9 R10: pair sweep over chain, timing, hit combination and kind
    for (int p = 0; p < NT/2; p++) begin
      for (int ch = 0; ch < 3; ch++)
        for (int ta = 0; ta < 2; ta++)
          for (int tb = 0; tb < 2; tb++) begin
            wcfg(2*p,   1'b1, 0, 1'b0, ta[0], 1'b1, (ch == 1), 64'h100 + 64'(p));
            wcfg(2*p+1, 1'b1, 0, 1'b0, tb[0], 1'b0, (ch == 2), 64'h200 + 64'(p));
            for (int h = 0; h < 4; h++) begin
              for (int u = 0; u < NT; u++) cur_v[u] = 64'hDEAD;
              cur_v[2*p]   = h[0] ? 64'h100 + 64'(p) : 64'h101 + 64'(p);
              cur_v[2*p+1] = h[1] ? 64'h200 + 64'(p) : 64'h201 + 64'(p);
              for (int k = 1; k < 4; k++) probe(k, "R6 R7 R8 R9 R10 pair");
            end
          end
      wcfg(2*p,   1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
      wcfg(2*p+1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    end

    // R10: priority across pairs on fetch
    wcfg(8, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h55);
    wcfg(6, 1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h55);
    for (int u = 0; u < NT; u++) cur_v[u] = 64'h55;
    probe(1, "R10 priority");
    wcfg(0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h55);
    probe(1, "R10 priority");
    wcfg(1, 1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b0, 64'h55);
    wcfg(0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    probe(1, "R10 priority");

    // R2: out-of-range indexes leave every trigger untouched
    for (int idx = NT; idx < 16; idx++) begin
      wcfg(idx, 1'b1, 0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h55);
      all_kinds("R2 bad index");
    end
    for (int idx = NT; idx < 16; idx++) begin
      wcfg(idx, 1'b0, 3, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0);
      all_kinds("R2 bad index");
    end

    // R1: reset in mid-run clears everything
    wcfg(4, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h55);
    probe(2, "R1 pre-reset");
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_clear();
    @(negedge clk_i);
    rst_ni = 1'b1;
    all_kinds("R1 after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule